// File: doc/BRIEF.md
# 1-Wire Search ROM Accelerator

This block is the datapath that resolves ROM identifier bits during a 1-Wire search. It sits between the master's byte engine and the time-slot generator. When search mode is on, a host byte written to the block starts one exchange. The byte carries one direction preference for each of four ROM bit positions. For each position the block asks the slot generator for three slots in order: a read of the true bit, a read of the complement, and a write of the chosen direction. Once all four positions are done, the block returns one response byte and pulses a done strobe.

In the response byte the four chosen ROM bits sit in the odd bit positions and the four discrepancy flags sit in the even positions. Sixteen exchanges walk a full 64-bit identifier, lowest nibble first. Before enabling search mode, the host issues the search command byte through the normal byte path. After the sixteenth exchange, the host resets the bus. The host runs the enumeration algorithm itself, choosing the preferences from the discrepancy flags.

Top module: `onewire_search_accel`

## Requirements
- R1: While `accel_en` is low, a pulse on `req_valid` starts nothing: no `slot_go` and no `resp_done`.
- R2: An accepted request produces exactly 12 slot requests (3 per position, 4 positions). After the acknowledge of the last slot, `resp_done` pulses for exactly one cycle.
- R3: For each position the slots run in a fixed order: read true bit, read complement, write direction. Both read slots drive `slot_drive` = 1, which releases the line.
- R4: Response layout: position k (k = 0 for the lowest ROM bit of the nibble) reports its chosen bit at `resp_byte[2k+1]` and its discrepancy flag at `resp_byte[2k]`. The preference for position k is taken from `req_byte[2k+1]`.
- R5: When the true read and the complement read differ, the chosen bit equals the true read and the discrepancy flag is 0.
- R6: When both reads are 0, the chosen bit equals the preference bit and the discrepancy flag is 1.
- R7: When both reads are 1 (no device responding), the chosen bit is 1 and the discrepancy flag is 1.
- R8: The value driven in the write slot of each position equals the chosen bit reported for that position.
- R9: A `req_valid` pulse that arrives while an exchange is in progress is ignored. The running exchange keeps its original preferences and produces one `resp_done`.
- R10: Deasserting `accel_en` during an exchange abandons it. No further slot requests are made, no `resp_done` follows, and the next exchange starts again from position 0.
- R11: After reset, `slot_go`, `resp_done` and `resp_byte` are all 0.
- R12: `resp_byte` keeps its value between `resp_done` pulses.
- R13: Sixteen exchanges against a bus of devices return the 64-bit identifier, with exchange i carrying ROM bits 4i to 4i+3. The discrepancy flag is set only where the still-active devices disagree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accel_en | input | 1 | Search mode enable; low returns the engine to plain byte transfers |
| req_valid | input | 1 | One-cycle pulse: host byte written |
| req_byte | input | 8 | Host byte; odd bits are direction preferences |
| slot_ack | input | 1 | Slot generator: requested slot finished |
| slot_sample | input | 1 | Line value sampled in the finished slot |
| slot_go | output | 1 | One-cycle request for a time slot |
| slot_drive | output | 1 | Bit to send in the requested slot (1 releases the line) |
| resp_byte | output | 8 | Packed chosen bits and discrepancy flags |
| resp_done | output | 1 | One-cycle strobe: `resp_byte` updated |

## Verification
The bench covers all four read-pair cases in one exchange and all three cases under opposite preferences, since a resolver with a swapped branch would report the wrong chosen bit or flag at a single position. A request arriving mid-exchange is sent with different preferences, so a design that relatched preferences or restarted would return visibly different bits or two done strobes. An abort in the middle of an exchange is followed by a fresh exchange, so a position counter left behind by the abort would misplace bits. A two-device search with both preference settings checks that only the true conflict bit is flagged and that the path branches in the preferred direction.

// File: rtl/sra_pkg.sv
package sra_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} sra_state_e;
  typedef enum logic [1:0] {PH_BIT, PH_CMP, PH_DIR} sra_phase_e;

  typedef struct packed {
    logic chosen;
    logic disc;
  } sra_res_t;

  // Resolve one ROM position from the true read, complement read and
  // host preference.
  function automatic sra_res_t sra_resolve(logic rd_true, logic rd_comp, logic pref);
    sra_res_t r;
    if (rd_true != rd_comp) begin
      r.chosen = rd_true;
      r.disc   = 1'b0;
    end else if (rd_true) begin
      r.chosen = 1'b1;   // nobody answered
      r.disc   = 1'b1;
    end else begin
      r.chosen = pref;   // devices disagree
      r.disc   = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/sra_slot_seq.sv
module sra_slot_seq
  import sra_pkg::*;
#(
  parameter int NPOS = 4,
  localparam int POS_W = (NPOS > 1) ? $clog2(NPOS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accel_en,
  input  logic             req_valid,
  input  logic             slot_ack,
  output logic             slot_go,
  output sra_phase_e       phase,
  output logic [POS_W-1:0] pos,
  output logic             evt_start,
  output logic             evt_taken,
  output logic             evt_last
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NPOS - 1);

  sra_state_e state;

  assign evt_start = (state == ST_IDLE) && accel_en && req_valid;
  assign evt_taken = (state == ST_WAIT) && accel_en && slot_ack;
  assign evt_last  = evt_taken && (phase == PH_DIR) && (pos == LAST_POS);
  assign slot_go   = (state == ST_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= PH_BIT;
      pos   <= '0;
    end else if (!accel_en) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          state <= ST_ISSUE;
          phase <= PH_BIT;
          pos   <= '0;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (slot_ack) begin
          case (phase)
            PH_BIT: begin phase <= PH_CMP; state <= ST_ISSUE; end
            PH_CMP: begin phase <= PH_DIR; state <= ST_ISSUE; end
            default: begin
              if (pos == LAST_POS) begin
                state <= ST_IDLE;
              end else begin
                pos   <= pos + 1'b1;
                phase <= PH_BIT;
                state <= ST_ISSUE;
              end
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sra_bit_resolver.sv
module sra_bit_resolver
  import sra_pkg::*;
#(
  parameter int NPOS = 4,
  localparam int POS_W = (NPOS > 1) ? $clog2(NPOS) : 1,
  localparam int BYTE_W = 2 * NPOS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_start,
  input  logic              evt_taken,
  input  sra_phase_e        phase,
  input  logic [POS_W-1:0]  pos,
  input  logic [BYTE_W-1:0] req_byte,
  input  logic              slot_sample,
  output sra_res_t          res
);
  logic [NPOS-1:0] pref_q;
  logic            true_q, comp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pref_q <= '0;
      true_q <= 1'b0;
      comp_q <= 1'b0;
    end else begin
      if (evt_start) begin
        for (int k = 0; k < NPOS; k++) pref_q[k] <= req_byte[2*k+1];
      end
      if (evt_taken && phase == PH_BIT) true_q <= slot_sample;
      if (evt_taken && phase == PH_CMP) comp_q <= slot_sample;
    end
  end

  assign res = sra_resolve(true_q, comp_q, pref_q[pos]);
endmodule

// File: rtl/sra_resp_pack.sv
module sra_resp_pack
  import sra_pkg::*;
#(
  parameter int NPOS = 4,
  localparam int POS_W = (NPOS > 1) ? $clog2(NPOS) : 1,
  localparam int BYTE_W = 2 * NPOS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_dir,
  input  logic              evt_last,
  input  logic [POS_W-1:0]  pos,
  input  sra_res_t          res,
  output logic [BYTE_W-1:0] resp_byte,
  output logic              resp_done
);
  logic [BYTE_W-1:0] merged;

  for (genvar k = 0; k < NPOS; k++) begin : g_pos
    logic [1:0] pair_q;
    assign merged[2*k+1 -: 2] = (evt_dir && pos == POS_W'(k)) ? {res.chosen, res.disc} : pair_q;
    always_ff @(posedge clk) begin
      if (!rst_n) pair_q <= 2'b00;
      else        pair_q <= merged[2*k+1 -: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_byte <= '0;
      resp_done <= 1'b0;
    end else begin
      resp_done <= evt_last;
      if (evt_last) resp_byte <= merged;
    end
  end
endmodule

// File: rtl/onewire_search_accel.sv
module onewire_search_accel
  import sra_pkg::*;
#(
  parameter int NPOS = 4,
  localparam int POS_W = (NPOS > 1) ? $clog2(NPOS) : 1,
  localparam int BYTE_W = 2 * NPOS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accel_en,
  input  logic              req_valid,
  input  logic [BYTE_W-1:0] req_byte,
  input  logic              slot_ack,
  input  logic              slot_sample,
  output logic              slot_go,
  output logic              slot_drive,
  output logic [BYTE_W-1:0] resp_byte,
  output logic              resp_done
);
  sra_phase_e       phase;
  logic [POS_W-1:0] pos;
  logic             evt_start, evt_taken, evt_last;
  logic             evt_dir;
  sra_res_t         res;

  assign evt_dir    = evt_taken && (phase == PH_DIR);
  assign slot_drive = (phase == PH_DIR) ? res.chosen : 1'b1;

  sra_slot_seq #(.NPOS(NPOS)) seq_i (
    .clk(clk), .rst_n(rst_n), .accel_en(accel_en), .req_valid(req_valid),
    .slot_ack(slot_ack), .slot_go(slot_go), .phase(phase), .pos(pos),
    .evt_start(evt_start), .evt_taken(evt_taken), .evt_last(evt_last)
  );

  sra_bit_resolver #(.NPOS(NPOS)) res_i (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_taken(evt_taken),
    .phase(phase), .pos(pos), .req_byte(req_byte), .slot_sample(slot_sample),
    .res(res)
  );

  sra_resp_pack #(.NPOS(NPOS)) pack_i (
    .clk(clk), .rst_n(rst_n), .evt_dir(evt_dir), .evt_last(evt_last),
    .pos(pos), .res(res), .resp_byte(resp_byte), .resp_done(resp_done)
  );
endmodule

// File: rtl/onewire_search_accel_chk.sv
module onewire_search_accel_chk #(
  parameter int NPOS = 4,
  localparam int BYTE_W = 2 * NPOS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accel_en,
  input logic              slot_go,
  input logic              slot_drive,
  input logic              resp_done,
  input logic [BYTE_W-1:0] resp_byte,
  input logic              evt_start,
  input logic              evt_taken,
  input logic [1:0]        phase
);
  logic [7:0] ack_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         ack_cnt <= '0;
    else if (evt_start) ack_cnt <= '0;
    else if (evt_taken) ack_cnt <= ack_cnt + 1'b1;
  end

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !accel_en |=> (!slot_go && !resp_done));

  p_slot_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |-> (ack_cnt == 8'(3 * NPOS)));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  p_go_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_go |=> !slot_go);

  p_read_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_go && phase != 2'd2) |-> slot_drive);

  p_resp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_done |-> $stable(resp_byte));
endmodule

bind onewire_search_accel onewire_search_accel_chk #(.NPOS(NPOS)) chk_i (
  .clk(clk), .rst_n(rst_n), .accel_en(accel_en), .slot_go(slot_go),
  .slot_drive(slot_drive), .resp_done(resp_done), .resp_byte(resp_byte),
  .evt_start(evt_start), .evt_taken(evt_taken), .phase(phase)
);

// File: tb/onewire_search_accel_tb_top.sv
`timescale 1ns/1ps
module onewire_search_accel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic accel_en = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_byte = '0;
  logic slot_ack, slot_sample;
  logic slot_go, slot_drive, resp_done;
  logic [7:0] resp_byte;

  always #5 clk = ~clk;

  onewire_search_accel dut_i (
    .clk(clk), .rst_n(rst_n), .accel_en(accel_en), .req_valid(req_valid),
    .req_byte(req_byte), .slot_ack(slot_ack), .slot_sample(slot_sample),
    .slot_go(slot_go), .slot_drive(slot_drive), .resp_byte(resp_byte),
    .resp_done(resp_done)
  );

  int checks = 0, errors = 0;
  int go_cnt = 0, done_cnt = 0, rd_err = 0, slot_n = 0;
  logic dev_mode = 1'b0;
  logic [3:0] tb_b = '0, tb_c = '0, wr_log = '0;
  logic [63:0] dev_id [2];
  logic [1:0] dev_act = '0;
  int ex_base = 0;
  int rp, rph, g;
  logic rv;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slot generator and bus model
  initial begin
    slot_ack = 1'b0;
    slot_sample = 1'b0;
    forever begin
      @(negedge clk);
      slot_ack = 1'b0;
      if (slot_go) begin
        rp = slot_n / 3;
        rph = slot_n % 3;
        if (rph < 2 && !slot_drive) rd_err++;
        rv = slot_drive;
        if (dev_mode) begin
          g = ex_base + rp;
          if (rph == 0) begin
            rv = 1'b1;
            for (int d = 0; d < 2; d++) if (dev_act[d]) rv = rv & dev_id[d][g];
          end else if (rph == 1) begin
            rv = 1'b1;
            for (int d = 0; d < 2; d++) if (dev_act[d]) rv = rv & ~dev_id[d][g];
          end else begin
            for (int d = 0; d < 2; d++) if (dev_id[d][g] != slot_drive) dev_act[d] = 1'b0;
          end
        end else if (rp < 4) begin
          if (rph == 0) rv = tb_b[rp];
          else if (rph == 1) rv = tb_c[rp];
        end
        if (rph == 2 && rp < 4) wr_log[rp] = slot_drive;
        slot_n++;
        go_cnt++;
        @(negedge clk);
        @(negedge clk);
        slot_ack = 1'b1;
        slot_sample = rv;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (resp_done) done_cnt++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic pulse_req(input logic [7:0] v);
    @(negedge clk);
    req_valid = 1'b1;
    req_byte = v;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output logic [7:0] r, output logic ok);
    ok = 1'b0;
    r = '0;
    for (int i = 0; i < 300 && !ok; i++) begin
      @(negedge clk);
      if (resp_done) begin ok = 1'b1; r = resp_byte; end
    end
  endtask

  function automatic logic [7:0] expect_byte(input logic [3:0] b, input logic [3:0] c, input logic [7:0] req);
    logic [7:0] e;
    for (int k = 0; k < 4; k++) begin
      e[2*k] = ~(b[k] ^ c[k]);
      e[2*k+1] = (b[k] ^ c[k]) ? b[k] : (b[k] | req[2*k+1]);
    end
    return e;
  endfunction

  function automatic logic [3:0] odd_bits(input logic [7:0] v);
    return {v[7], v[5], v[3], v[1]};
  endfunction

  task automatic t_reset();
    check("R11 slot_go after reset", slot_go, 0);
    check("R11 resp_done after reset", resp_done, 0);
    check("R11 resp_byte after reset", resp_byte, 0);
  endtask

  task automatic t_disabled();
    int g0 = go_cnt, d0 = done_cnt;
    accel_en = 1'b0;
    pulse_req(8'hFF);
    repeat (40) @(negedge clk);
    check("R1 no slots while disabled", go_cnt - g0, 0);
    check("R1 no done while disabled", done_cnt - d0, 0);
  endtask

  task automatic t_table(input logic [3:0] b, input logic [3:0] c, input logic [7:0] req, input string tag);
    logic [7:0] r, e;
    logic ok;
    int g0 = go_cnt, d0 = done_cnt;
    dev_mode = 1'b0;
    tb_b = b; tb_c = c; slot_n = 0; rd_err = 0; wr_log = 'x;
    accel_en = 1'b1;
    pulse_req(req);
    wait_done(r, ok);
    e = expect_byte(b, c, req);
    check({tag, " R2 done seen"}, ok, 1);
    check({tag, " R4 R5 R6 R7 response byte"}, r, e);
    check({tag, " R8 written directions"}, wr_log, odd_bits(e));
    check({tag, " R2 slot count"}, go_cnt - g0, 12);
    check({tag, " R3 read slots release"}, rd_err, 0);
    repeat (3) @(negedge clk);
    check({tag, " R2 single done"}, done_cnt - d0, 1);
  endtask

  task automatic t_busy();
    logic [7:0] r, e, mid;
    logic ok;
    int d0 = done_cnt;
    dev_mode = 1'b0;
    tb_b = 4'b0000; tb_c = 4'b0000; slot_n = 0;
    accel_en = 1'b1;
    mid = resp_byte;
    pulse_req(8'hAA);
    repeat (3) @(negedge clk);
    pulse_req(8'h00);
    check("R12 resp_byte held mid exchange", resp_byte, mid);
    wait_done(r, ok);
    e = expect_byte(4'b0000, 4'b0000, 8'hAA);
    check("R9 busy request ignored byte", r, e);
    repeat (40) @(negedge clk);
    check("R9 busy request one done", done_cnt - d0, 1);
    check("R9 slot count", slot_n, 12);
  endtask

  task automatic t_abort();
    int g1, d0 = done_cnt;
    logic [7:0] held;
    dev_mode = 1'b0;
    tb_b = 4'b1111; tb_c = 4'b0000; slot_n = 0;
    accel_en = 1'b1;
    held = resp_byte;
    pulse_req(8'h00);
    while (slot_n < 5) @(negedge clk);
    accel_en = 1'b0;
    repeat (2) @(negedge clk);
    g1 = go_cnt;
    repeat (40) @(negedge clk);
    check("R10 no slots after abort", go_cnt - g1, 0);
    check("R10 no done after abort", done_cnt - d0, 0);
    check("R12 resp_byte kept across abort", resp_byte, held);
    t_table(4'b0101, 4'b1010, 8'h00, "R10 after abort");
  endtask

  task automatic t_search(input logic [7:0] pref, input logic [63:0] exp_id, input string tag);
    logic [63:0] got_id, got_disc, exp_disc;
    logic [7:0] r;
    logic ok;
    dev_mode = 1'b1;
    dev_act = 2'b11;
    accel_en = 1'b1;
    got_id = '0; got_disc = '0;
    exp_disc = 64'h20;  // ids first differ at ROM bit 5
    for (int i = 0; i < 16; i++) begin
      ex_base = 4 * i;
      slot_n = 0;
      pulse_req(pref);
      wait_done(r, ok);
      for (int k = 0; k < 4; k++) begin
        got_id[4*i+k] = r[2*k+1];
        got_disc[4*i+k] = r[2*k];
      end
    end
    check({tag, " R13 identifier"}, got_id, exp_id);
    check({tag, " R13 discrepancy flags"}, got_disc, exp_disc);
    accel_en = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [7:0] held;
    dev_id[0] = 64'hA5C3_19E7_0F3B_2D40;
    dev_id[1] = 64'hA5C3_19E7_0F3B_2D40 ^ 64'h8000_0000_0000_0020;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    // mixed pairs: pos0 (0,1) pos1 (1,0) pos2 (0,0) pos3 (1,1)
    t_table(4'b1010, 4'b1001, 8'hFF, "mixed pref1");
    t_table(4'b1010, 4'b1001, 8'h00, "mixed pref0");
    t_table(4'b0000, 4'b0000, 8'h88, "all conflict");
    t_table(4'b1111, 4'b1111, 8'h00, "no device");
    t_table(4'b0110, 4'b1001, 8'hAA, "clean read");
    held = resp_byte;
    accel_en = 1'b0;
    pulse_req(8'h55);
    repeat (20) @(negedge clk);
    check("R12 resp_byte held while idle", resp_byte, held);
    t_busy();
    t_abort();
    t_search(8'hAA, dev_id[1], "pref ones");
    t_search(8'h00, dev_id[0], "pref zeros");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule